// File: doc/BRIEF.md
# Real-time clock prescaler with halt and clear control

This block turns a 32768 Hz oscillator into the time bases that a real-time clock needs. It produces a single-cycle seconds pulse for the calendar counters, a run flag, and one selectable source pulse for a fixed-cycle countdown timer. The timer source can be 4096 Hz, 64 Hz, 1 Hz or once per minute. The oscillator arrives as a clock enable, `osc_en_i`, that is high for one cycle of the system clock per oscillator period.

Two halt bits control the block. The pause bit freezes the sub-second divider and the seconds-of-minute count. The clear bit freezes them as well and also holds them at zero. Counting resumes only when both bits are 0. The fast stages from the oscillator down to 4096 Hz never stop, so a timer that runs from 4096 Hz keeps running while the block is halted. The clear bit is released by hardware when the bus reports a STOP or repeated START while its timeout window is open.

Top module: `rtc_prescaler`

## Requirements
- R1: While the block runs, `sec_tick_o` is a single-cycle pulse. It rises in the cycle after every 2^(LOW_W+MID_W+HI_W)-th accepted `osc_en_i`. With the bench parameters and `osc_en_i` held high, that is once every 32 cycles.
- R2: While `stop_o` is 1, no `sec_tick_o` pulse is produced.
- R3: `run_o` is 1 only when both `stop_o` and `reset_o` are 0. Clearing only one bit while the other is still 1 leaves `run_o` at 0.
- R4: While `reset_o` is 1, the sub-second divider and the seconds-of-minute count are held at zero. After both bits clear, the first `sec_tick_o` coincides with the 2^(MID_W+HI_W)-th 4096 Hz tick.
- R5: Under the pause bit alone, the sub-second divider keeps its value. After the restart, the next `sec_tick_o` comes after the remaining number of 4096 Hz ticks.
- R6: The stages from the oscillator down to 4096 Hz run in every state. With `tsel_i` = 00, `tmr_tick_o` pulses once per 2^LOW_W accepted enables even while the block is halted.
- R7: With `tsel_i` = 01 (64 Hz), 10 (1 Hz) or 11 (minute), `tmr_tick_o` stays 0 while `run_o` is 0.
- R8: With `tsel_i` = 11, `tmr_tick_o` pulses in the same cycle as every MIN_MOD-th `sec_tick_o` after a clear.
- R9: A `bus_rel_i` pulse with no write in the same cycle sets `reset_o` to 0 in the next cycle and leaves `stop_o` unchanged.
- R10: When `wr_en_i` and `bus_rel_i` are high in the same cycle, the written values win. `stop_o` takes `wr_stop_i` and `reset_o` takes `wr_reset_i`.
- R11: After `rst_n` is asserted, both bits read 0, no pulses are produced, and all counts are zero. The first `sec_tick_o` therefore follows the 2^(LOW_W+MID_W+HI_W)-th enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_en_i | input | 1 | One pulse per oscillator period |
| wr_en_i | input | 1 | Write strobe for both halt bits |
| wr_stop_i | input | 1 | Pause bit value to write |
| wr_reset_i | input | 1 | Clear bit value to write |
| bus_rel_i | input | 1 | Bus STOP or repeated START seen in the timeout window |
| tsel_i | input | 2 | Timer source: 00 4096 Hz, 01 64 Hz, 10 1 Hz, 11 minute |
| stop_o | output | 1 | Pause bit readback |
| reset_o | output | 1 | Clear bit readback |
| run_o | output | 1 | Calendar counters may advance |
| sec_tick_o | output | 1 | 1 Hz pulse to the calendar |
| tmr_tick_o | output | 1 | Selected timer source pulse |

## Verification
A divider that is off by even one count shifts every later `sec_tick_o`. The scoreboard catches this in the first seconds pulse after the error, which is at most one second of oscillator time later. A clear that fails to zero the divider shows up as a short first second after restart. A pause that disturbs the divider shows up as a wrong remaining count, and a minute count that was not cleared makes the first minute pulse arrive early. A wrong halt bit is visible on `stop_o`, `reset_o` and `run_o` in the cycle after the write or bus event.

// File: rtl/rtc_pre_pkg.sv
package rtc_pre_pkg;
   typedef enum logic [1:0] {
      SRC_4K  = 2'b00,
      SRC_64  = 2'b01,
      SRC_1S  = 2'b10,
      SRC_MIN = 2'b11
   } tsrc_e;
endpackage

// File: rtl/rtc_pre_ctrl.sv
module rtc_pre_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en_i,
   input  logic wr_stop_i,
   input  logic wr_reset_i,
   input  logic bus_rel_i,
   output logic stop_q,
   output logic reset_q,
   output logic run_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stop_q  <= 1'b0;
         reset_q <= 1'b0;
      end else if (wr_en_i) begin
         stop_q  <= wr_stop_i;
         reset_q <= wr_reset_i;
      end else if (bus_rel_i) begin
         reset_q <= 1'b0;
      end
   end

   assign run_o = !stop_q && !reset_q;

   // R9: hardware release clears only the clear bit
   p_bus_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rel_i && !wr_en_i) |=> !reset_q);
   p_stop_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rel_i && !wr_en_i) |=> (stop_q == $past(stop_q)));
   // R10: software write wins over hardware release
   p_write_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> ((reset_q == $past(wr_reset_i)) && (stop_q == $past(wr_stop_i))));
endmodule

// File: rtl/rtc_pre_div.sv
module rtc_pre_div #(
   parameter int LOW_W = 3,
   parameter int MID_W = 6,
   parameter int HI_W  = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic osc_en_i,
   input  logic run_i,
   input  logic clr_i,
   output logic t4k_o,
   output logic t64_o,
   output logic t1_o
);
   localparam int UP_W = MID_W + HI_W;
   localparam logic [LOW_W-1:0] LOW_ONE = 1;
   localparam logic [UP_W-1:0]  UP_ONE  = 1;

   if (LOW_W < 1) begin : g_bad_low
      $error("rtc_pre_div: LOW_W must be at least 1");
   end
   if (MID_W < 1 || HI_W < 1) begin : g_bad_up
      $error("rtc_pre_div: MID_W and HI_W must be at least 1");
   end

   logic [LOW_W-1:0] low_q;
   logic [UP_W-1:0]  up_q;

   // fast stages never halt
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        low_q <= '0;
      else if (osc_en_i) low_q <= low_q + LOW_ONE;
   end

   assign t4k_o = osc_en_i && (&low_q);

   // gated stages: held at zero under clear, frozen under pause
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               up_q <= '0;
      else if (clr_i)           up_q <= '0;
      else if (t4k_o && run_i)  up_q <= up_q + UP_ONE;
   end

   assign t64_o = t4k_o && run_i && (&up_q[MID_W-1:0]);
   assign t1_o  = t4k_o && run_i && (&up_q);

   p_low_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
      osc_en_i |=> (low_q == LOW_W'($past(low_q) + LOW_ONE)));
   p_clr_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (up_q == '0));
   p_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !clr_i) |=> $stable(up_q));
endmodule

// File: rtl/rtc_pre_min.sv
module rtc_pre_min #(
   parameter int MIN_MOD = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sec_i,
   input  logic clr_i,
   output logic min_o
);
   localparam int SW = (MIN_MOD > 1) ? $clog2(MIN_MOD) : 1;
   localparam logic [SW-1:0] LAST = SW'(MIN_MOD - 1);
   localparam logic [SW-1:0] ONE  = 1;

   if (MIN_MOD < 2) begin : g_bad_mod
      $error("rtc_pre_min: MIN_MOD must be at least 2");
   end

   logic [SW-1:0] sec_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sec_q <= '0;
      else if (clr_i) sec_q <= '0;
      else if (sec_i) sec_q <= (sec_q == LAST) ? '0 : sec_q + ONE;
   end

   assign min_o = sec_i && (sec_q == LAST);

   p_min_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (sec_q == '0));
   p_min_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sec_i && !clr_i) |=> $stable(sec_q));
endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int LOW_W   = 3,
   parameter int MID_W   = 6,
   parameter int HI_W    = 6,
   parameter int MIN_MOD = 60,
   parameter bit REG_OUT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       osc_en_i,
   input  logic       wr_en_i,
   input  logic       wr_stop_i,
   input  logic       wr_reset_i,
   input  logic       bus_rel_i,
   input  logic [1:0] tsel_i,
   output logic       stop_o,
   output logic       reset_o,
   output logic       run_o,
   output logic       sec_tick_o,
   output logic       tmr_tick_o
);
   import rtc_pre_pkg::*;

   logic stop_q, reset_q, run;
   logic t4k, t64, t1, tmin, tmr_sel;
   tsrc_e src;

   rtc_pre_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_stop_i(wr_stop_i),
      .wr_reset_i(wr_reset_i), .bus_rel_i(bus_rel_i),
      .stop_q(stop_q), .reset_q(reset_q), .run_o(run)
   );

   rtc_pre_div #(.LOW_W(LOW_W), .MID_W(MID_W), .HI_W(HI_W)) u_div (
      .clk(clk), .rst_n(rst_n), .osc_en_i(osc_en_i), .run_i(run),
      .clr_i(reset_q), .t4k_o(t4k), .t64_o(t64), .t1_o(t1)
   );

   rtc_pre_min #(.MIN_MOD(MIN_MOD)) u_min (
      .clk(clk), .rst_n(rst_n), .sec_i(t1), .clr_i(reset_q), .min_o(tmin)
   );

   assign src = tsrc_e'(tsel_i);

   always_comb begin
      case (src)
         SRC_4K:  tmr_sel = t4k;
         SRC_64:  tmr_sel = t64;
         SRC_1S:  tmr_sel = t1;
         default: tmr_sel = tmin;
      endcase
   end

   assign stop_o  = stop_q;
   assign reset_o = reset_q;
   assign run_o   = run;

   if (REG_OUT) begin : g_reg_out
      logic sec_q, tmr_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sec_q <= 1'b0;
            tmr_q <= 1'b0;
         end else begin
            sec_q <= t1;
            tmr_q <= tmr_sel;
         end
      end
      assign sec_tick_o = sec_q;
      assign tmr_tick_o = tmr_q;

      p_sec_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
         sec_tick_o |=> !sec_tick_o);
      p_sec_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (!run_o) |=> !sec_tick_o);
      p_tmr_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (!run_o && tsel_i != 2'b00) |=> !tmr_tick_o);
   end else begin : g_comb_out
      assign sec_tick_o = t1;
      assign tmr_tick_o = tmr_sel;

      p_sec_halt_r2: assert property (@(posedge clk) disable iff (!rst_n)
         !(sec_tick_o && !run_o));
      p_tmr_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !(tmr_tick_o && !run_o && tsel_i != 2'b00));
   end
endmodule

// File: tb/rtc_prescaler_test.sv
module rtc_prescaler_test;
   localparam int LW = 1, MW = 2, HW = 2, MM = 4;
   localparam int LOWN = 1 << LW;
   localparam int MIDN = 1 << MW;
   localparam int UPN  = 1 << (MW + HW);

   logic clk = 1'b0, rst_n = 1'b0;
   logic osc_en = 1'b0, wr_en = 1'b0, wr_stop = 1'b0, wr_reset = 1'b0, bus_rel = 1'b0;
   logic [1:0] tsel = 2'b00;
   logic stop_o, reset_o, run_o, sec_tick_o, tmr_tick_o;

   int checks = 0, fails = 0;
   bit done = 0;

   rtc_prescaler #(.LOW_W(LW), .MID_W(MW), .HI_W(HW), .MIN_MOD(MM), .REG_OUT(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .osc_en_i(osc_en), .wr_en_i(wr_en), .wr_stop_i(wr_stop),
      .wr_reset_i(wr_reset), .bus_rel_i(bus_rel), .tsel_i(tsel), .stop_o(stop_o),
      .reset_o(reset_o), .run_o(run_o), .sec_tick_o(sec_tick_o), .tmr_tick_o(tmr_tick_o)
   );

   always #2 clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // ---------------- scoreboard ----------------
   typedef struct packed {logic s; logic t; logic r; logic st; logic rs;} exp_t;
   exp_t sbq[$];
   int m_low = 0, m_up = 0, m_sec = 0;
   bit m_stop = 0, m_rst = 0;
   bit m_run, m_t4, m_t64, m_t1, m_tm, m_tt;

   always @(posedge clk) begin
      exp_t e;
      #1;
      if (!rst_n) begin
         m_low = 0; m_up = 0; m_sec = 0; m_stop = 0; m_rst = 0;
         e = '{s:1'b0, t:1'b0, r:1'b1, st:1'b0, rs:1'b0};
      end else begin
         m_run = !m_stop && !m_rst;
         m_t4  = osc_en && (m_low == LOWN - 1);
         m_t64 = m_t4 && m_run && ((m_up % MIDN) == MIDN - 1);
         m_t1  = m_t4 && m_run && (m_up == UPN - 1);
         m_tm  = m_t1 && (m_sec == MM - 1);
         case (tsel)
            2'b00: m_tt = m_t4;
            2'b01: m_tt = m_t64;
            2'b10: m_tt = m_t1;
            default: m_tt = m_tm;
         endcase
         if (osc_en) m_low = (m_low + 1) % LOWN;
         if (m_rst) m_up = 0; else if (m_t4 && m_run) m_up = (m_up + 1) % UPN;
         if (m_rst) m_sec = 0; else if (m_t1) m_sec = (m_sec + 1) % MM;
         if (wr_en) begin m_stop = wr_stop; m_rst = wr_reset; end
         else if (bus_rel) m_rst = 0;
         e = '{s:m_t1, t:m_tt, r:(!m_stop && !m_rst), st:m_stop, rs:m_rst};
      end
      sbq.push_back(e);
   end

   always @(posedge clk) begin
      exp_t e;
      #2;
      if (sbq.size() > 0) begin
         e = sbq.pop_front();
         chk("R1 scoreboard sec tick", int'(sec_tick_o), int'(e.s));
         chk("R7 scoreboard timer tick", int'(tmr_tick_o), int'(e.t));
         chk("R3 scoreboard run flag", int'(run_o), int'(e.r));
         chk("R2 scoreboard stop bit", int'(stop_o), int'(e.st));
         chk("R9 scoreboard reset bit", int'(reset_o), int'(e.rs));
      end
   end

   // ---------------- driver helpers ----------------
   task automatic samp();
      @(posedge clk); #3;
   endtask

   task automatic wr(input logic s, input logic r);
      @(negedge clk); wr_en = 1'b1; wr_stop = s; wr_reset = r;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic set_osc(input logic v);
      @(negedge clk); osc_en = v;
   endtask

   // count 4096 Hz pulses (tsel 00) up to and including the seconds pulse
   task automatic count_to_sec(output int n);
      n = 0;
      for (int i = 0; i < 2000; i++) begin
         samp();
         if (tmr_tick_o) n++;
         if (sec_tick_o) break;
      end
   endtask

   initial begin
      int n, m, s;
      // R11 reset state
      repeat (3) samp();
      chk("R11 stop after reset", int'(stop_o), 0);
      chk("R11 reset after reset", int'(reset_o), 0);
      chk("R11 no sec tick in reset", int'(sec_tick_o), 0);
      @(negedge clk); rst_n = 1'b1; osc_en = 1'b1;
      n = 0;
      for (int i = 0; i < 200; i++) begin
         samp(); n++;
         if (sec_tick_o) break;
      end
      chk("R11 enables to first sec tick", n, LOWN * UPN);
      samp();
      chk("R1 sec tick single cycle", int'(sec_tick_o), 0);
      n = 1;
      for (int i = 0; i < 200; i++) begin
         samp(); n++;
         if (sec_tick_o) break;
      end
      chk("R1 sec tick period", n, LOWN * UPN);

      // R2/R6: pause, fast stage still ticks
      set_osc(1'b0); wr(1'b1, 1'b0); samp();
      chk("R2 stop readback", int'(stop_o), 1);
      chk("R3 run low under stop", int'(run_o), 0);
      set_osc(1'b1);
      n = 0; s = 0;
      for (int i = 0; i < 64; i++) begin
         samp(); if (tmr_tick_o) n++; if (sec_tick_o) s++;
      end
      chk("R6 4096 Hz ticks while halted", n, 64 / LOWN);
      chk("R2 no sec tick while stopped", s, 0);
      // R7: slower sources suppressed
      for (int k = 1; k < 4; k++) begin
         @(negedge clk); tsel = 2'(k);
         n = 0;
         for (int i = 0; i < 80; i++) begin samp(); if (tmr_tick_o) n++; end
         chk("R7 slow source suppressed while halted", n, 0);
      end

      // R3: both bits needed
      set_osc(1'b0); @(negedge clk); tsel = 2'b00;
      wr(1'b1, 1'b1); wr(1'b0, 1'b1); samp();
      chk("R3 run stays low with clear set", int'(run_o), 0);
      wr(1'b1, 1'b0); samp();
      chk("R3 run stays low with pause set", int'(run_o), 0);
      wr(1'b1, 1'b1); wr(1'b0, 1'b0); samp();
      chk("R3 run high with both clear", int'(run_o), 1);

      // R4: full second after clear
      set_osc(1'b1);
      count_to_sec(n);
      chk("R4 4096 Hz ticks to first sec after clear", n, UPN);

      // R5: pause keeps position
      n = 0;
      for (int i = 0; i < 200 && n < 5; i++) begin samp(); if (tmr_tick_o) n++; end
      set_osc(1'b0); wr(1'b1, 1'b0); set_osc(1'b1);
      s = 0;
      for (int i = 0; i < 40; i++) begin samp(); if (sec_tick_o) s++; end
      chk("R5 no sec tick while paused", s, 0);
      set_osc(1'b0); wr(1'b0, 1'b0); set_osc(1'b1);
      count_to_sec(n);
      chk("R5 remaining ticks after pause", n, UPN - 5);

      // R8: minute pulse
      set_osc(1'b0); wr(1'b0, 1'b1); wr(1'b0, 1'b0);
      @(negedge clk); tsel = 2'b11; osc_en = 1'b1;
      m = 0; s = 0;
      for (int i = 0; i < 2000; i++) begin
         samp();
         if (sec_tick_o) m++;
         if (tmr_tick_o) begin s = int'(sec_tick_o); break; end
      end
      chk("R8 seconds per minute pulse", m, MM);
      chk("R8 minute pulse with sec tick", s, 1);

      // R9: bus release
      set_osc(1'b0); @(negedge clk); tsel = 2'b00;
      wr(1'b1, 1'b1);
      @(negedge clk); bus_rel = 1'b1;
      @(negedge clk); bus_rel = 1'b0;
      chk("R9 clear bit released", int'(reset_o), 0);
      chk("R9 pause bit kept", int'(stop_o), 1);
      // R10: write priority
      @(negedge clk); wr_en = 1'b1; wr_stop = 1'b0; wr_reset = 1'b1; bus_rel = 1'b1;
      @(negedge clk); wr_en = 1'b0; bus_rel = 1'b0;
      chk("R10 write beats release (clear)", int'(reset_o), 1);
      chk("R10 write beats release (pause)", int'(stop_o), 0);

      // random traffic, checked by the scoreboard
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         osc_en   = ($urandom % 4) != 0;
         wr_en    = ($urandom % 60) == 0;
         wr_stop  = ($urandom % 3) == 0;
         wr_reset = ($urandom % 3) == 0;
         bus_rel  = ($urandom % 40) == 0;
         if (($urandom % 200) == 0) tsel = 2'($urandom % 4);
      end
      @(negedge clk); wr_en = 1'b0; bus_rel = 1'b0;
      repeat (4) samp();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule